// File: doc/BRIEF.md
# Bus-Initiator Data Parity Checker and Reporter

This block watches the data phases of transactions that the device itself starts on a parallel PCI bus and checks each one for even parity. The parity of the 32 address/data lines and the 4 command/byte-enable lines of a data phase is computed in the clock where that phase is marked valid. It is then compared with the parity line sampled one clock later. Reporting is gated by the parity-error-response enable taken from the command register. With the enable set, a mismatch drives the active-low parity-error line, pulses a set request for the data-parity-detected status bit (status bit 8), and holds that bit as a sticky flag. When the errored phase belonged to a read, it also sets the detected-parity-error status bit (status bit 15).

The parity-error line is driven by a three-state machine with these states: `ST_RELEASE` (output enable low, line released), `ST_ASSERT` (line driven low) and `ST_RESTORE` (line driven high for one clock before release). Its transitions are as follows. A registered error hit moves any state to `ST_ASSERT`. `ST_ASSERT` goes to `ST_RESTORE` when no new hit is present. `ST_RESTORE` goes to `ST_RELEASE` when no new hit is present. Without a hit, `ST_RELEASE` stays where it is. Each sticky status bit is cleared by its own write-one-to-clear strobe, which the surrounding register file decodes from a status write.

Top module: `pci_init_parity_reporter`

## Requirements
- R1: Parity is even: a data phase marked by `phase_valid` in clock N has an error when `par_in` sampled in clock N+1 differs from the XOR of `ad_in[31:0]` and `cbe_in[3:0]` sampled in clock N. Clocks without `phase_valid` are never checked.
- R2: When `perr_resp_en` is low in the clock where the parity line is sampled, a mismatch produces no line drive, no set pulse and no sticky change.
- R3: A reported error raises `set_dpd_o` (status bit 8) for the one clock that follows the parity sample. `sticky_dpd_o` is 1 from the next clock on.
- R4: `set_dpe_o` and `sticky_dpe_o` (status bit 15) react only to errors whose data phase had `is_read` = 1. An error on a write phase (`is_read` = 0) sets only the bit-8 flags.
- R5: `perr_n_o` is 0 with `perr_oe_o` = 1 for exactly one clock, starting two clocks after the clock of the errored data phase.
- R6: After the low clock, `perr_n_o` is 1 with `perr_oe_o` = 1 for one clock, and `perr_oe_o` is 0 in the clock after that. Errors in consecutive data phases keep the line low for consecutive clocks.
- R7: `clr_dpd` clears only `sticky_dpd_o` and `clr_dpe` clears only `sticky_dpe_o`. A clear strobe leaves the other bit unchanged.
- R8: When a set and a clear of the same bit meet in one clock, the bit ends up 1.
- R9: After reset, `perr_oe_o` = 0, `perr_n_o` = 1, and both set pulses and both sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | Sampled address/data bus |
| cbe_in | input | 4 | Sampled command/byte-enable bus |
| par_in | input | 1 | Sampled parity line |
| phase_valid | input | 1 | A data phase of an initiated transaction completes this clock |
| is_read | input | 1 | Current transaction is a read |
| perr_resp_en | input | 1 | Parity-error-response enable from command register |
| clr_dpd | input | 1 | Write-one-to-clear strobe for status bit 8 |
| clr_dpe | input | 1 | Write-one-to-clear strobe for status bit 15 |
| perr_n_o | output | 1 | Active-low parity-error drive value |
| perr_oe_o | output | 1 | Output enable for the parity-error line |
| set_dpd_o | output | 1 | Set pulse for status bit 8 |
| set_dpe_o | output | 1 | Set pulse for status bit 15 |
| sticky_dpd_o | output | 1 | Sticky status bit 8 |
| sticky_dpe_o | output | 1 | Sticky status bit 15 |

## Verification
Suppose the two-stage compare pipeline holds a wrong parity or a wrong read flag. The fault then shows at the set pulses one clock after the parity sample and at the line drive one clock later. An error that slips past the state machine shows up at once as a missing low clock, a missing restore clock or an output enable that stays high, because each state maps directly to a pin pair. A corrupted sticky bit stays visible until its clear strobe, so checks after clears, including a clear paired with a set, expose it within one clock.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    typedef enum logic [1:0] {
        ST_RELEASE = 2'd0,
        ST_ASSERT  = 2'd1,
        ST_RESTORE = 2'd2
    } perr_state_e;

    localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/ppr_parity_calc.sv
module ppr_parity_calc
    import pci_par_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CBE_W  = DATA_W / LANE_BITS
) (
    input  logic [DATA_W-1:0] ad,
    input  logic [CBE_W-1:0]  cbe,
    output logic              even_par
);

    logic [CBE_W-1:0] lane_par;

    // one byte lane plus its byte enable per slice
    for (genvar g = 0; g < CBE_W; g++) begin : g_lane
        assign lane_par[g] = (^ad[g*LANE_BITS +: LANE_BITS]) ^ cbe[g];
    end

    assign even_par = ^lane_par;

endmodule

// File: rtl/ppr_phase_check.sv
module ppr_phase_check #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CBE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [CBE_W-1:0]  cbe,
    input  logic              par,
    input  logic              phase_valid,
    input  logic              is_read,
    input  logic              resp_en,
    output logic              err_hit,
    output logic              err_read
);

    logic calc_par;
    logic s1_valid;
    logic s1_par;
    logic s1_read;
    logic mismatch;

    ppr_parity_calc #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_calc (
        .ad       (ad),
        .cbe      (cbe),
        .even_par (calc_par)
    );

    // stage 1: hold computed parity of the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_par   <= 1'b0;
            s1_read  <= 1'b0;
        end else begin
            s1_valid <= phase_valid;
            s1_par   <= calc_par;
            s1_read  <= is_read;
        end
    end

    assign mismatch = s1_valid && resp_en && (s1_par != par);

    // stage 2: compare against parity line sampled one clock later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_hit  <= 1'b0;
            err_read <= 1'b0;
        end else begin
            err_hit  <= mismatch;
            err_read <= mismatch && s1_read;
        end
    end

    assert_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |-> $past(phase_valid, 2));

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |-> $past(resp_en));

    assert_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_read |-> err_hit);

endmodule

// File: rtl/ppr_perr_fsm.sv
module ppr_perr_fsm
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_hit,
    output logic perr_n,
    output logic perr_oe
);

    perr_state_e state;
    perr_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RELEASE: state_nx = err_hit ? ST_ASSERT : ST_RELEASE;
            ST_ASSERT:  state_nx = err_hit ? ST_ASSERT : ST_RESTORE;
            ST_RESTORE: state_nx = err_hit ? ST_ASSERT : ST_RELEASE;
            default:    state_nx = ST_RELEASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RELEASE;
        else        state <= state_nx;
    end

    always_comb begin
        perr_n  = 1'b1;
        perr_oe = 1'b0;
        unique case (state)
            ST_RELEASE: begin perr_n = 1'b1; perr_oe = 1'b0; end
            ST_ASSERT:  begin perr_n = 1'b0; perr_oe = 1'b1; end
            ST_RESTORE: begin perr_n = 1'b1; perr_oe = 1'b1; end
            default:    begin perr_n = 1'b1; perr_oe = 1'b0; end
        endcase
    end

    assert_drive_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |=> (!perr_n && perr_oe));

    assert_restore_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && !perr_n && !err_hit) |=> (perr_oe && perr_n));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && perr_n && !err_hit) |=> !perr_oe);

endmodule

// File: rtl/ppr_status_bits.sv
module ppr_status_bits #(
    parameter int unsigned NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_req,
    input  logic [NBITS-1:0] clr_req,
    output logic [NBITS-1:0] sticky
);

    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          sticky[g] <= 1'b0;
            else if (set_req[g]) sticky[g] <= 1'b1;
            else if (clr_req[g]) sticky[g] <= 1'b0;
        end

        assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[g] |=> sticky[g]);

        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[g] && !set_req[g]) |=> !sticky[g]);

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[g] && set_req[g]) |=> sticky[g]);

        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_req[g] && !set_req[g]) |=> $stable(sticky[g]));
    end

endmodule

// File: rtl/pci_init_parity_reporter.sv
module pci_init_parity_reporter #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CBE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [CBE_W-1:0]  cbe_in,
    input  logic              par_in,
    input  logic              phase_valid,
    input  logic              is_read,
    input  logic              perr_resp_en,
    input  logic              clr_dpd,
    input  logic              clr_dpe,
    output logic              perr_n_o,
    output logic              perr_oe_o,
    output logic              set_dpd_o,
    output logic              set_dpe_o,
    output logic              sticky_dpd_o,
    output logic              sticky_dpe_o
);

    localparam int unsigned N_STAT = 2;

    logic              err_hit;
    logic              err_read;
    logic [N_STAT-1:0] stat_set;
    logic [N_STAT-1:0] stat_clr;
    logic [N_STAT-1:0] stat_q;

    ppr_phase_check #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .ad          (ad_in),
        .cbe         (cbe_in),
        .par         (par_in),
        .phase_valid (phase_valid),
        .is_read     (is_read),
        .resp_en     (perr_resp_en),
        .err_hit     (err_hit),
        .err_read    (err_read)
    );

    ppr_perr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_hit (err_hit),
        .perr_n  (perr_n_o),
        .perr_oe (perr_oe_o)
    );

    // index 0: status bit 8, index 1: status bit 15
    assign stat_set = {err_read, err_hit};
    assign stat_clr = {clr_dpe, clr_dpd};

    ppr_status_bits #(.NBITS(N_STAT)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (stat_set),
        .clr_req (stat_clr),
        .sticky  (stat_q)
    );

    assign set_dpd_o    = err_hit;
    assign set_dpe_o    = err_read;
    assign sticky_dpd_o = stat_q[0];
    assign sticky_dpe_o = stat_q[1];

endmodule

// File: tb/test_pci_init_parity_reporter.sv
`timescale 1ns/1ps
module test_pci_init_parity_reporter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        par_in = 1'b0;
    logic        phase_valid = 1'b0;
    logic        is_read = 1'b0;
    logic        perr_resp_en = 1'b0;
    logic        clr_dpd = 1'b0;
    logic        clr_dpe = 1'b0;
    logic        perr_n_o, perr_oe_o, set_dpd_o, set_dpe_o, sticky_dpd_o, sticky_dpe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pci_init_parity_reporter i_pci_init_parity_reporter (
        .clk (clk), .rst_n (rst_n), .ad_in (ad_in), .cbe_in (cbe_in),
        .par_in (par_in), .phase_valid (phase_valid), .is_read (is_read),
        .perr_resp_en (perr_resp_en), .clr_dpd (clr_dpd), .clr_dpe (clr_dpe),
        .perr_n_o (perr_n_o), .perr_oe_o (perr_oe_o), .set_dpd_o (set_dpd_o),
        .set_dpe_o (set_dpe_o), .sticky_dpd_o (sticky_dpd_o), .sticky_dpe_o (sticky_dpe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic even_of(input logic [31:0] a, input logic [3:0] c);
        return ^{a, c};
    endfunction

    task automatic clear_all();
        @(negedge clk); clr_dpd = 1'b1; clr_dpe = 1'b1;
        @(negedge clk); clr_dpd = 1'b0; clr_dpe = 1'b0;
    endtask

    // one data phase; bad=1 flips the parity line
    task automatic one_phase(input string tag, input logic [31:0] a, input logic [3:0] c,
                             input logic bad, input logic rd, input logic en);
        logic err;
        err = bad & en;
        clear_all();
        perr_resp_en = en;
        @(negedge clk); phase_valid = 1'b1; ad_in = a; cbe_in = c; is_read = rd;
        @(negedge clk); phase_valid = 1'b0; par_in = even_of(a, c) ^ bad;
                        ad_in = ~a; cbe_in = ~c;
        @(negedge clk); par_in = 1'b0;
        chk({tag, " R3 set_dpd"}, set_dpd_o, err);
        chk({tag, " R4 set_dpe"}, set_dpe_o, err & rd);
        @(negedge clk);
        chk({tag, " R5 perr_n low"}, perr_n_o, !err);
        chk({tag, " R5 perr_oe"}, perr_oe_o, err);
        chk({tag, " R3 sticky_dpd"}, sticky_dpd_o, err);
        chk({tag, " R4 sticky_dpe"}, sticky_dpe_o, err & rd);
        @(negedge clk);
        chk({tag, " R6 restore high"}, perr_n_o, 1'b1);
        chk({tag, " R6 restore oe"}, perr_oe_o, err);
        @(negedge clk);
        chk({tag, " R6 released"}, perr_oe_o, 1'b0);
    endtask

    task automatic test_reset();
        chk("R9 oe", perr_oe_o, 1'b0);
        chk("R9 perr_n", perr_n_o, 1'b1);
        chk("R9 pulses", {set_dpd_o, set_dpe_o}, 2'b00);
        chk("R9 sticky", {sticky_dpd_o, sticky_dpe_o}, 2'b00);
    endtask

    task automatic test_patterns();
        one_phase("R1 good read", 32'h1234_5678, 4'h0, 1'b0, 1'b1, 1'b1);
        one_phase("R1 bad read", 32'hDEAD_BEEF, 4'hA, 1'b1, 1'b1, 1'b1);
        one_phase("R1 bad read zero", 32'h0000_0000, 4'h0, 1'b1, 1'b1, 1'b1);
        one_phase("R1 good ones", 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0, 1'b1);
        one_phase("R4 bad write", 32'h8000_0001, 4'h3, 1'b1, 1'b0, 1'b1);
        one_phase("R2 disabled read", 32'hCAFE_0001, 4'h6, 1'b1, 1'b1, 1'b0);
        one_phase("R2 disabled write", 32'h0F0F_0F0F, 4'h1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_back_to_back();
        clear_all();
        perr_resp_en = 1'b1;
        @(negedge clk); phase_valid = 1'b1; ad_in = 32'h0000_0003; cbe_in = 4'h0; is_read = 1'b1;
        @(negedge clk); par_in = 1'b1; ad_in = 32'h0000_0001; cbe_in = 4'h0;
        @(negedge clk); phase_valid = 1'b0; par_in = 1'b0;
        @(negedge clk);
        chk("R6 b2b first low", {perr_n_o, perr_oe_o}, 2'b01);
        @(negedge clk);
        chk("R6 b2b second low", {perr_n_o, perr_oe_o}, 2'b01);
        @(negedge clk);
        chk("R6 b2b restore", {perr_n_o, perr_oe_o}, 2'b11);
        @(negedge clk);
        chk("R6 b2b release", perr_oe_o, 1'b0);
    endtask

    task automatic test_clear_select();
        one_phase("R7 setup", 32'h5555_0000, 4'h2, 1'b1, 1'b1, 1'b1);
        @(negedge clk); clr_dpd = 1'b1;
        @(negedge clk); clr_dpd = 1'b0;
        chk("R7 dpd cleared", sticky_dpd_o, 1'b0);
        chk("R7 dpe kept", sticky_dpe_o, 1'b1);
        @(negedge clk); clr_dpe = 1'b1;
        @(negedge clk); clr_dpe = 1'b0;
        chk("R7 dpe cleared", sticky_dpe_o, 1'b0);
    endtask

    task automatic test_set_wins();
        clear_all();
        perr_resp_en = 1'b1;
        @(negedge clk); phase_valid = 1'b1; ad_in = 32'h0000_0010; cbe_in = 4'h0; is_read = 1'b1;
        @(negedge clk); phase_valid = 1'b0; par_in = 1'b0;
        @(negedge clk); clr_dpd = 1'b1; clr_dpe = 1'b1;
        @(negedge clk); clr_dpd = 1'b0; clr_dpe = 1'b0;
        chk("R8 dpd set wins", sticky_dpd_o, 1'b1);
        chk("R8 dpe set wins", sticky_dpe_o, 1'b1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_patterns();
        test_back_to_back();
        test_clear_select();
        test_set_wins();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule